// File: doc/BRIEF.md
# Wavelet-Walsh Correlating Bit Recovery

This block turns a stream of received signed samples into recovered binary data. Each accepted sample is scaled by a signed two-bit Walsh chip and then by one coefficient of a fixed ten-point wavelet template. The scaled values are summed across one template period, and the sign of that sum gives one recovered bit. Symbol alignment, chip generation and any framing after the bit are handled elsewhere.

A small window sequencer tracks where each accepted sample falls inside the template. It has three named states. W_OPEN means the next sample takes coefficient 0 and starts a fresh sum. W_FILL covers coefficients 1 to 8. W_CLOSE means the next sample takes coefficient 9 and ends the window. The transitions are W_OPEN to W_FILL on any accepted sample, W_FILL to W_CLOSE on the sample that takes coefficient 8, and W_CLOSE to W_OPEN on the sample that takes coefficient 9. When in_valid is low, the sequencer stays where it is.

The multiply-accumulate path has three register stages: the chip product, the coefficient product, and the accumulate-and-decide stage. Window-start and window-end tags travel through the pipeline with each product, so gaps in in_valid never mix products from two windows.

Top module: `wwrx_top`

## Requirements
- R1: While rst is high at a rising edge, the next cycle shows win_trig and bit_done low. After reset, the first accepted sample takes coefficient index 0.
- R2: A rising edge with in_valid low does not advance the coefficient index and does not change the running sum.
- R3: Accepted samples take coefficients in index order 0 to 9 and then wrap. The signed values in that order are 4, 7, -21, 28, -76, -21, 195, -76, -104, 59.
- R4: Each term is sample × chip × coefficient. The sample is 14-bit two's complement. The chip is 2-bit two's complement: 2'b00 = 0, 2'b01 = +1, 2'b10 = -2, 2'b11 = -1.
- R5: win_trig is high for exactly one cycle, the cycle that follows the edge accepting the tenth sample of a window.
- R6: bit_done is high for exactly one cycle, the cycle that follows the second edge after the edge accepting the tenth sample. bit_out is valid in that cycle.
- R7: bit_out is 1 when the window sum is zero or positive, and 0 when it is negative.
- R8: Each window's sum contains only its own ten terms. Nothing carries over from the previous window.
- R9: Full-scale samples and chips across a whole window give the exact sign of the window sum, with no wrap-around.
- R10: A reset in the middle of a window discards the partial window and any products still in the pipeline. No bit_done is produced for it, and the next window starts again at coefficient 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample and chip are accepted on this edge |
| in_sample | input | 14 | Received sample, two's complement |
| in_chip | input | 2 | Walsh chip, two's complement |
| win_trig | output | 1 | One-cycle pulse when the window's last sample is accepted |
| bit_out | output | 1 | Recovered bit, 1 for a non-negative sum |
| bit_done | output | 1 | One-cycle strobe marking bit_out valid |

## Verification
The bench targets these corner cases:

- Coefficient order and sign. It sends windows where only one position carries a non-zero sample. A design that read the table out of order, or with a wrong sign, would flip the decided bit for that position.
- Chip decoding. It drives all four chip codes. A mis-decoded -2 or -1 would invert or zero the decision.
- Idle gaps. Random idle gaps check that a stalled cycle neither consumes a coefficient nor adds a stale product. Either fault would shift the trigger and strobe timing against the model.
- Window boundaries and range. A strong positive window is followed by a weakly negative one, which exposes a sum that is not cleared. Full-scale windows of both signs expose an accumulator that is too narrow. A mid-window reset must leave no strobe behind.

// File: rtl/wwrx_pkg.sv
package wwrx_pkg;

    localparam int SAMPLE_W = 14;
    localparam int CHIP_W   = 2;
    localparam int COEF_W   = 10;
    localparam int WIN_LEN  = 10;
    localparam int IDX_W    = $clog2(WIN_LEN);
    localparam int PROD1_W  = SAMPLE_W + CHIP_W;
    localparam int PROD2_W  = PROD1_W + COEF_W;
    localparam int ACC_W    = PROD2_W + $clog2(WIN_LEN);

    typedef enum logic [1:0] {
        W_OPEN  = 2'd0,
        W_FILL  = 2'd1,
        W_CLOSE = 2'd2
    } win_state_t;

    // Wavelet template, one signed value per window position.
    function automatic logic signed [COEF_W-1:0] wavelet_coef(input logic [IDX_W-1:0] pos);
        logic signed [COEF_W-1:0] v;
        case (pos)
            4'd0:    v = 10'sd4;
            4'd1:    v = 10'sd7;
            4'd2:    v = -10'sd21;
            4'd3:    v = 10'sd28;
            4'd4:    v = -10'sd76;
            4'd5:    v = -10'sd21;
            4'd6:    v = 10'sd195;
            4'd7:    v = -10'sd76;
            4'd8:    v = -10'sd104;
            4'd9:    v = 10'sd59;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/wwrx_seq.sv
module wwrx_seq
    import wwrx_pkg::*;
#(
    parameter int LEN = WIN_LEN,
    localparam int IW = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic [IW-1:0] pos,
    output logic          win_first,
    output logic          win_last,
    output logic          trig
);

    win_state_t    state_q, state_d;
    logic [IW-1:0] pos_q;
    logic          trig_q;

    // Next-state logic: moves only on accepted samples.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_OPEN:  if (in_valid) state_d = W_FILL;
            W_FILL:  if (in_valid && pos_q == IW'(LEN - 2)) state_d = W_CLOSE;
            W_CLOSE: if (in_valid) state_d = W_OPEN;
            default: state_d = W_OPEN;
        endcase
    end

    // State register and window position.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_OPEN;
            pos_q   <= '0;
        end else if (in_valid) begin
            state_q <= state_d;
            pos_q   <= (state_q == W_CLOSE) ? '0 : pos_q + 1'b1;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= in_valid && (state_q == W_CLOSE);
        end
    end

    assign pos       = pos_q;
    assign win_first = (state_q == W_OPEN);
    assign win_last  = (state_q == W_CLOSE);
    assign trig      = trig_q;

endmodule

// File: rtl/wwrx_mac.sv
module wwrx_mac
    import wwrx_pkg::*;
#(
    parameter int SW = SAMPLE_W,
    parameter int CW = CHIP_W,
    parameter int KW = COEF_W,
    parameter int AW = ACC_W,
    localparam int P1W = SW + CW,
    localparam int P2W = P1W + KW
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] in_sample,
    input  logic signed [CW-1:0] in_chip,
    input  logic signed [KW-1:0] in_coef,
    input  logic                 in_first,
    input  logic                 in_last,
    output logic                 dec_bit,
    output logic                 dec_done
);

    // Stage 1: sample x chip.
    logic                  v1_q, f1_q, l1_q;
    logic signed [P1W-1:0] p1_q;
    logic signed [KW-1:0]  k1_q;
    logic signed [P1W-1:0] s_ext, c_ext, mul1;

    always_comb begin
        s_ext = P1W'(in_sample);
        c_ext = P1W'(in_chip);
        mul1  = s_ext * c_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q <= 1'b0;
            f1_q <= 1'b0;
            l1_q <= 1'b0;
            p1_q <= '0;
            k1_q <= '0;
        end else begin
            v1_q <= in_valid;
            f1_q <= in_first;
            l1_q <= in_last;
            p1_q <= mul1;
            k1_q <= in_coef;
        end
    end

    // Stage 2: product x wavelet coefficient.
    logic                  v2_q, f2_q, l2_q;
    logic signed [P2W-1:0] p2_q;
    logic signed [P2W-1:0] a_ext, k_ext, mul2;

    always_comb begin
        a_ext = P2W'(p1_q);
        k_ext = P2W'(k1_q);
        mul2  = a_ext * k_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v2_q <= 1'b0;
            f2_q <= 1'b0;
            l2_q <= 1'b0;
            p2_q <= '0;
        end else begin
            v2_q <= v1_q;
            f2_q <= f1_q;
            l2_q <= l1_q;
            p2_q <= mul2;
        end
    end

    // Stage 3: accumulate and decide on the sign.
    logic signed [AW-1:0] acc_q, addend, sum_d;
    logic                 bit_q, done_q;

    always_comb begin
        addend = AW'(p2_q);
        sum_d  = f2_q ? addend : acc_q + addend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            bit_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= v2_q && l2_q;
            if (v2_q) begin
                acc_q <= sum_d;
                if (l2_q) bit_q <= ~sum_d[AW-1];
            end
        end
    end

    assign dec_bit  = bit_q;
    assign dec_done = done_q;

endmodule

// File: rtl/wwrx_top.sv
module wwrx_top
    import wwrx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [CHIP_W-1:0]   in_chip,
    output logic                win_trig,
    output logic                bit_out,
    output logic                bit_done
);

    logic [IDX_W-1:0]         pos;
    logic                     first, last;
    logic signed [COEF_W-1:0] coef;

    wwrx_seq #(.LEN(WIN_LEN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .pos       (pos),
        .win_first (first),
        .win_last  (last),
        .trig      (win_trig)
    );

    assign coef = wavelet_coef(pos);

    wwrx_mac #(
        .SW (SAMPLE_W),
        .CW (CHIP_W),
        .KW (COEF_W),
        .AW (ACC_W)
    ) u_mac (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample ($signed(in_sample)),
        .in_chip   ($signed(in_chip)),
        .in_coef   (coef),
        .in_first  (first),
        .in_last   (last),
        .dec_bit   (bit_out),
        .dec_done  (bit_done)
    );

endmodule

// File: rtl/wwrx_chk.sv
module wwrx_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic win_trig,
    input logic bit_done
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!win_trig && !bit_done));

    // R2
    idle_no_trig_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !win_trig);

    // R5
    trig_single_chk: assert property (@(posedge clk) disable iff (rst)
        win_trig |=> !win_trig);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        bit_done |=> !bit_done);

    // R6
    done_after_trig_chk: assert property (@(posedge clk) disable iff (rst)
        bit_done |-> $past(win_trig, 2));

endmodule

bind wwrx_top wwrx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .win_trig (win_trig),
    .bit_done (bit_done)
);

// File: tb/wwrx_top_test.sv
module wwrx_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [13:0] in_sample = '0;
    logic [1:0]  in_chip = '0;
    logic        win_trig, bit_out, bit_done;

    always #2 clk = ~clk;

    wwrx_top uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .in_chip   (in_chip),
        .win_trig  (win_trig),
        .bit_out   (bit_out),
        .bit_done  (bit_done)
    );

    int coef_tbl [10] = '{4, 7, -21, 28, -76, -21, 195, -76, -104, 59};

    typedef struct { longint due; bit b; } ev_t;
    ev_t    done_evq[$];
    longint trig_evq[$];
    longint cyc = 0;
    int     m_idx = 0;
    longint m_sum = 0;
    int     checks = 0, errors = 0;
    string  cur_req = "R1";
    bit     finished = 0;

    // Behavioural reference: updated on each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_idx = 0;
            m_sum = 0;
            done_evq.delete();
            trig_evq.delete();
        end else if (in_valid) begin
            longint term;
            term  = longint'($signed(in_sample)) * longint'($signed(in_chip)) * longint'(coef_tbl[m_idx]);
            m_sum = (m_idx == 0) ? term : m_sum + term;
            if (m_idx == 9) begin
                ev_t e;
                e.due = cyc + 2;
                e.b   = (m_sum >= 0);
                trig_evq.push_back(cyc);
                done_evq.push_back(e);
                m_idx = 0;
            end else begin
                m_idx++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Compare against the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (!finished) begin
            bit exp_t, exp_d, exp_b;
            exp_t = 0; exp_d = 0; exp_b = 0;
            if (trig_evq.size() > 0 && trig_evq[0] == cyc) begin
                exp_t = 1;
                void'(trig_evq.pop_front());
            end
            if (done_evq.size() > 0 && done_evq[0].due == cyc) begin
                exp_d = 1;
                exp_b = done_evq[0].b;
                void'(done_evq.pop_front());
            end
            check(win_trig === exp_t, (cur_req == "R1") ? "R1" : "R5", "win_trig", int'(win_trig), int'(exp_t));
            check(bit_done === exp_d, (cur_req == "R1") ? "R1" : "R6", "bit_done", int'(bit_done), int'(exp_d));
            if (exp_d)
                check(bit_out === exp_b, cur_req, "bit_out", int'(bit_out), int'(exp_b));
        end
    end

    task automatic send(input int s, input int c);
        in_valid  = 1'b1;
        in_sample = s[13:0];
        in_chip   = c[1:0];
        @(negedge clk);
        in_valid  = 1'b0;
        in_sample = '0;
        in_chip   = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One window: a non-zero sample only at position k.
    task automatic lone_window(input int k, input int s, input int c);
        for (int i = 0; i < 10; i++) send((i == k) ? s : 0, c);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        report();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle(3);
        check(win_trig === 1'b0 && bit_done === 1'b0, "R1", "outputs in reset", int'({win_trig, bit_done}), 0);
        rst = 1'b0;
        idle(2);

        // R3: coefficient order, one active position per window
        cur_req = "R3";
        for (int k = 0; k < 10; k++) lone_window(k, 1, 1);
        idle(4);

        // R4: all four chip codes on position 6
        cur_req = "R4";
        lone_window(6, 500, 0);
        lone_window(6, 500, 1);
        lone_window(6, 500, -1);
        lone_window(6, 500, -2);
        lone_window(6, -300, -2);
        idle(4);

        // R7: zero sum decides 1
        cur_req = "R7";
        lone_window(0, 0, 1);
        lone_window(4, 1, 0);
        idle(4);

        // R8: strong positive window then weak negative one
        cur_req = "R8";
        lone_window(6, 8000, 1);
        lone_window(2, 1, 1);
        idle(4);

        // R9: full-scale windows of both signs
        cur_req = "R9";
        for (int i = 0; i < 10; i++) send(coef_tbl[i] < 0 ? -8192 : 8191, -2);
        for (int i = 0; i < 10; i++) send(coef_tbl[i] < 0 ? 8191 : -8192, -2);
        idle(4);

        // R2: random idle gaps between accepted samples
        cur_req = "R2";
        for (int n = 0; n < 60; n++) begin
            idle($urandom_range(0, 3));
            send(int'($urandom_range(0, 16383)) - 8192, int'($urandom_range(0, 3)));
        end
        idle(6);

        // R10: reset mid-window, then a clean window
        cur_req = "R10";
        for (int i = 0; i < 5; i++) send(4000, 1);
        rst = 1'b1;
        idle(1);
        rst = 1'b0;
        lone_window(2, 100, 1);
        for (int i = 0; i < 9; i++) send(2000, 1);
        rst = 1'b1;
        idle(1);
        check(bit_done === 1'b0, "R10", "strobe after mid-window reset", int'(bit_done), 0);
        rst = 1'b0;
        idle(3);
        check(bit_done === 1'b0 && win_trig === 1'b0, "R10", "no stale strobe", int'({win_trig, bit_done}), 0);
        lone_window(0, 100, 1);
        idle(4);

        // Back-to-back random windows
        cur_req = "R3";
        for (int n = 0; n < 80; n++)
            send(int'($urandom_range(0, 16383)) - 8192, int'($urandom_range(0, 3)));
        idle(6);

        report();
    end

endmodule